// File: doc/BRIEF.md
# Pointer Register File with Post-Increment Fetch

This block keeps a bank of sixteen 16-bit pointer registers and serves all of them with one increment/decrement unit. A sequencer runs each command in fixed machine phases of eight clocks. A command can step a selected pointer up or down by one, or overwrite one byte of it. It can also fetch a memory byte through the pointer into an 8-bit accumulator and then advance that pointer by one.

The surrounding processor presents a command with a 4-bit register select on the last clock of a phase. It then waits while the block is busy. The address output always shows the pointer the block is working on. Memory answers combinationally on the read-data input and is sampled on the last clock of the read phase. At most one arithmetic step happens per command, so the single shared adder is never contended.

Top module: `ptr_file_seq`

## Requirements
- R1: Reset clears all sixteen registers and the accumulator to zero, drops busy and done, and restarts the clock-in-phase counter at 0 on the first clock after reset release.
- R2: cmd_op codes are 1 = increment, 2 = decrement, 3 = fetch-and-increment, 4 = load low byte and 5 = load high byte. Codes 0, 6 and 7 are never accepted and change nothing.
- R3: A command is accepted only on the last clock of a phase, which is clock 7 counting from 0 after reset, with cmd_valid high and busy low. Busy rises on the next clock, so every command starts on clock 0 of a phase.
- R4: Increment, decrement and both byte loads keep busy high for exactly 16 clocks (two phases). A fetch keeps it high for exactly 24 clocks (three phases).
- R5: done is high for exactly one clock, the last busy clock of the command. Busy is low on the next clock.
- R6: Increment adds one modulo 2^16, so 0xFFFF becomes 0x0000. Decrement subtracts one modulo 2^16, so 0x0000 becomes 0xFFFF. No flag is raised in either case.
- R7: Load low replaces bits 7:0 of the selected register with load_data and leaves bits 15:8 unchanged. Load high replaces bits 15:8 and leaves bits 7:0 unchanged. load_data is captured when the command is accepted.
- R8: During a fetch, mem_addr holds the pointer's pre-increment value for the first two phases. The accumulator takes mem_rdata as it stands on the last clock of the second phase. The incremented pointer appears on mem_addr from the first clock of the third phase.
- R9: mem_addr always shows the register named by the most recently accepted select. Only that register is written, once per command, at the end of the command's second phase. Every other register keeps its value.
- R10: While busy, cmd_valid and every command field are ignored. Such a command is not queued, does not extend busy and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 3 | Command code |
| cmd_sel | input | 4 | Register select |
| load_data | input | 8 | Byte for the load commands |
| mem_rdata | input | 8 | Memory read data |
| mem_addr | output | 16 | Current pointer value, used as the memory address |
| acc | output | 8 | Accumulator |
| busy | output | 1 | Command in progress |
| done | output | 1 | Last clock of the command |

## Verification
The assertions check the following on every cycle:
- busy only rises on clock 0 of a phase;
- each busy period lasts 16 or 24 clocks;
- done is a single pulse followed by idle;
- mem_addr holds still between register writes;
- an increment or decrement moves the shown pointer by exactly one, wrapping at the ends;
- a low-byte load keeps the high byte.

Other behaviour only the bench scenarios can show:
- which cycle the accumulator captures memory data;
- that commands arriving while busy or with unused codes are discarded;
- that loads to one register leave the other fifteen intact.

// File: rtl/ptrf_pkg.sv
package ptrf_pkg;

   typedef enum logic [2:0] {
      OP_NONE  = 3'd0,
      OP_INC   = 3'd1,
      OP_DEC   = 3'd2,
      OP_FETCH = 3'd3,
      OP_LDLO  = 3'd4,
      OP_LDHI  = 3'd5
   } ptr_op_e;

   function automatic logic op_legal(input logic [2:0] code);
      return (code >= 3'd1) && (code <= 3'd5);
   endfunction

endpackage

// File: rtl/ptrf_incdec.sv
module ptrf_incdec #(
   parameter int DW        = 16,
   parameter int INC_STYLE = 0
) (
   input  logic [DW-1:0] a,
   input  logic          down,
   output logic [DW-1:0] y
);

   if (DW < 2) begin : g_bad_width
      $error("ptrf_incdec: DW must be at least 2");
   end

   if (INC_STYLE == 0) begin : g_split
      // separate +1 / -1 paths, selected at the output
      always_comb y = down ? (a - DW'(1)) : (a + DW'(1));
   end else begin : g_single
      // one adder, operand is +1 or all ones
      logic [DW-1:0] step;
      always_comb begin
         step = down ? {DW{1'b1}} : DW'(1);
         y    = a + step;
      end
   end

endmodule

// File: rtl/ptrf_bank.sv
module ptrf_bank #(
   parameter int NREG = 16,
   parameter int DW   = 16,
   localparam int SELW = $clog2(NREG)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we,
   input  logic [SELW-1:0] sel,
   input  logic [DW-1:0]   wdata,
   output logic [DW-1:0]   rdata
);

   if (NREG != (1 << SELW)) begin : g_bad_depth
      $error("ptrf_bank: NREG must be a power of two");
   end

   logic [DW-1:0] regs [NREG];

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            regs[i] <= '0;
         else if (we && (sel == SELW'(i)))
            regs[i] <= wdata;
      end
   end

   assign rdata = regs[sel];

endmodule

// File: rtl/ptrf_seq.sv
module ptrf_seq
   import ptrf_pkg::*;
#(
   parameter int NREG   = 16,
   parameter int BW     = 8,
   parameter int PH_LEN = 8,
   localparam int SELW = $clog2(NREG),
   localparam int CW   = $clog2(PH_LEN)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cmd_valid,
   input  logic [2:0]      cmd_op,
   input  logic [SELW-1:0] cmd_sel,
   input  logic [BW-1:0]   load_data,
   output logic            busy,
   output logic            done,
   output logic            reg_we,
   output logic            acc_we,
   output ptr_op_e         op_q,
   output logic [SELW-1:0] sel_q,
   output logic [BW-1:0]   ld_q
);

   if (PH_LEN < 2) begin : g_bad_phase
      $error("ptrf_seq: PH_LEN must be at least 2");
   end

   logic [CW-1:0] slot;
   logic [1:0]    ph;
   logic          slot_end;
   logic [1:0]    last_ph;
   logic          accept;

   assign slot_end = (slot == CW'(PH_LEN - 1));
   assign last_ph  = (op_q == OP_FETCH) ? 2'd2 : 2'd1;
   assign accept   = cmd_valid && !busy && slot_end && op_legal(cmd_op);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot  <= '0;
         ph    <= '0;
         busy  <= 1'b0;
         op_q  <= OP_NONE;
         sel_q <= '0;
         ld_q  <= '0;
      end else begin
         slot <= slot_end ? '0 : slot + 1'b1;
         if (accept) begin
            busy  <= 1'b1;
            ph    <= '0;
            op_q  <= ptr_op_e'(cmd_op);
            sel_q <= cmd_sel;
            ld_q  <= load_data;
         end else if (busy && slot_end) begin
            if (ph == last_ph)
               busy <= 1'b0;
            else
               ph <= ph + 2'd1;
         end
      end
   end

   // every command writes its register at the close of its second phase
   assign reg_we = busy && slot_end && (ph == 2'd1);
   assign acc_we = reg_we && (op_q == OP_FETCH);
   assign done   = busy && slot_end && (ph == last_ph);

endmodule

// File: rtl/ptr_file_seq.sv
module ptr_file_seq
   import ptrf_pkg::*;
#(
   parameter int NREG      = 16,
   parameter int DW        = 16,
   parameter int BW        = 8,
   parameter int PH_LEN    = 8,
   parameter int INC_STYLE = 0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cmd_valid,
   input  logic [2:0]              cmd_op,
   input  logic [$clog2(NREG)-1:0] cmd_sel,
   input  logic [BW-1:0]           load_data,
   input  logic [BW-1:0]           mem_rdata,
   output logic [DW-1:0]           mem_addr,
   output logic [BW-1:0]           acc,
   output logic                    busy,
   output logic                    done
);

   localparam int SELW = $clog2(NREG);

   if (DW != 2 * BW) begin : g_bad_split
      $error("ptr_file_seq: DW must be twice BW");
   end

   logic            reg_we;
   logic            acc_we;
   ptr_op_e         op_q;
   logic [SELW-1:0] sel_q;
   logic [BW-1:0]   ld_q;
   logic [DW-1:0]   rd;
   logic [DW-1:0]   step_y;
   logic [DW-1:0]   wdata;

   ptrf_seq #(.NREG(NREG), .BW(BW), .PH_LEN(PH_LEN)) u_seq (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_sel(cmd_sel), .load_data(load_data), .busy(busy), .done(done),
      .reg_we(reg_we), .acc_we(acc_we), .op_q(op_q), .sel_q(sel_q), .ld_q(ld_q)
   );

   ptrf_bank #(.NREG(NREG), .DW(DW)) u_bank (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .sel(sel_q),
      .wdata(wdata), .rdata(rd)
   );

   ptrf_incdec #(.DW(DW), .INC_STYLE(INC_STYLE)) u_step (
      .a(rd), .down(op_q == OP_DEC), .y(step_y)
   );

   always_comb begin
      case (op_q)
         OP_LDLO: wdata = {rd[DW-1:BW], ld_q};
         OP_LDHI: wdata = {ld_q, rd[BW-1:0]};
         default: wdata = step_y;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         acc <= '0;
      else if (acc_we)
         acc <= mem_rdata;
   end

   assign mem_addr = rd;

endmodule

// File: rtl/ptrf_chk.sv
module ptrf_chk #(
   parameter int DW     = 16,
   parameter int BW     = 8,
   parameter int PH_LEN = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          busy,
   input logic          done,
   input logic          reg_we,
   input logic [2:0]    op_q,
   input logic [DW-1:0] mem_addr
);

   localparam int CW  = $clog2(PH_LEN) + 1;
   localparam int BLW = $clog2(3 * PH_LEN + 2);

   logic [CW-1:0]  c_slot;
   logic [BLW-1:0] blen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         c_slot <= '0;
         blen   <= '0;
      end else begin
         c_slot <= (c_slot == CW'(PH_LEN - 1)) ? '0 : c_slot + 1'b1;
         blen   <= busy ? blen + 1'b1 : '0;
      end
   end

   AST_START_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (c_slot == '0)); // R3

   AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (blen == BLW'(2 * PH_LEN) || blen == BLW'(3 * PH_LEN))); // R4

   AST_DONE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy); // R5

   AST_DONE_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!busy && !done)); // R5

   AST_INC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && op_q == 3'd1) |=> (mem_addr == $past(mem_addr) + DW'(1))); // R6

   AST_DEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && op_q == 3'd2) |=> (mem_addr == $past(mem_addr) - DW'(1))); // R6

   AST_LOW_LOAD_KEEPS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && op_q == 3'd4) |=> (mem_addr[DW-1:BW] == $past(mem_addr[DW-1:BW]))); // R7

   AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && !$past(reg_we)) |-> $stable(mem_addr)); // R9

endmodule

bind ptr_file_seq ptrf_chk #(.DW(DW), .BW(BW), .PH_LEN(PH_LEN)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
   .reg_we(reg_we), .op_q(op_q), .mem_addr(mem_addr)
);

// File: tb/tb_ptr_file_seq.sv
module tb_ptr_file_seq;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [2:0]  cmd_op = 3'd0;
   logic [3:0]  cmd_sel = 4'd0;
   logic [7:0]  load_data = 8'd0;
   logic [7:0]  mem_rdata;
   logic [15:0] mem_addr;
   logic [7:0]  acc;
   logic        busy;
   logic        done;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   function automatic logic [7:0] mem_byte(input logic [15:0] a);
      return a[7:0] ^ a[15:8] ^ 8'hA5;
   endfunction

   assign mem_rdata = mem_byte(mem_addr);

   ptr_file_seq dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_sel(cmd_sel), .load_data(load_data), .mem_rdata(mem_rdata),
      .mem_addr(mem_addr), .acc(acc), .busy(busy), .done(done)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic finish_up();
      if (!finished) begin
         finished = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   // behavioural reference: cycles counted since reset, commands by elapsed clock
   logic [15:0] m_regs [16];
   logic [7:0]  m_acc;
   int m_cnt, m_k, m_op, m_sel;
   bit m_busy;
   logic [7:0] m_ld;

   function automatic int m_len(input int op);
      return (op == 3) ? 24 : 16;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 16; i++) m_regs[i] = 16'h0000;
         m_acc = 8'h00; m_cnt = 0; m_k = 0; m_op = 0; m_sel = 0; m_busy = 0; m_ld = 8'h00;
         cyc = 0;
      end else begin
         cyc = cyc + 1;
         if (m_busy) begin
            if (m_k == 15) begin
               case (m_op)
                  1: m_regs[m_sel] = m_regs[m_sel] + 16'd1;
                  2: m_regs[m_sel] = m_regs[m_sel] - 16'd1;
                  3: begin
                     m_acc = mem_byte(m_regs[m_sel]);
                     m_regs[m_sel] = m_regs[m_sel] + 16'd1;
                  end
                  4: m_regs[m_sel][7:0] = m_ld;
                  5: m_regs[m_sel][15:8] = m_ld;
                  default: ;
               endcase
            end
            if (m_k == m_len(m_op) - 1) m_busy = 0;
            else m_k = m_k + 1;
         end else if (cmd_valid && m_cnt == 7 && cmd_op >= 3'd1 && cmd_op <= 3'd5) begin
            m_busy = 1; m_k = 0; m_op = int'(cmd_op); m_sel = int'(cmd_sel); m_ld = load_data;
         end
         m_cnt = (m_cnt + 1) % 8;
      end
   end

   // compare against the reference on every clock, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk(busy === m_busy, "R4 busy vs model", 32'(busy), 32'(m_busy));
         chk(done === (m_busy && m_k == m_len(m_op) - 1), "R5 done vs model",
             32'(done), 32'(m_busy && m_k == m_len(m_op) - 1));
         chk(acc === m_acc, "R8 acc vs model", 32'(acc), 32'(m_acc));
         chk(mem_addr === m_regs[m_sel], "R9 mem_addr vs model", 32'(mem_addr), 32'(m_regs[m_sel]));
      end
   end

   always @(posedge clk) begin
      if (cyc > 150000) begin
         chk(1'b0, "watchdog expired", 32'(cyc), 32'd150000);
         finish_up();
      end
   end

   logic [15:0] addr_tr [32];
   logic [7:0]  acc_tr [32];

   task automatic run_cmd(input logic [2:0] op, input logic [3:0] sel, input logic [7:0] d,
                          input bit noisy, output int ncyc);
      int dn;
      int dn_at;
      cmd_op = op; cmd_sel = sel; load_data = d; cmd_valid = 1'b1;
      do @(negedge clk); while (!busy);
      chk((cyc % 8) == 0, "R3 start on phase clock 0", 32'(cyc % 8), 32'd0);
      if (noisy) begin
         cmd_op = 3'd2; cmd_sel = sel + 4'd1; load_data = ~d;
      end else begin
         cmd_valid = 1'b0;
      end
      ncyc = 0; dn = 0; dn_at = -1;
      while (busy) begin
         if (ncyc < 32) begin
            addr_tr[ncyc] = mem_addr;
            acc_tr[ncyc] = acc;
         end
         ncyc++;
         if (done) begin
            dn++; dn_at = ncyc; cmd_valid = 1'b0;
         end
         @(negedge clk);
      end
      cmd_valid = 1'b0;
      chk(dn == 1, "R5 single done pulse", 32'(dn), 32'd1);
      chk(dn_at == ncyc, "R5 done on last busy clock", 32'(dn_at), 32'(ncyc));
      chk(ncyc == ((op == 3'd3) ? 24 : 16), "R4 busy length", 32'(ncyc), 32'((op == 3'd3) ? 24 : 16));
   endtask

   initial begin
      int n;
      logic [7:0] acc_before;
      repeat (3) @(negedge clk);
      chk(mem_addr == 16'h0000, "R1 reset mem_addr", 32'(mem_addr), 32'h0);
      chk(acc == 8'h00, "R1 reset acc", 32'(acc), 32'h0);
      chk(busy == 1'b0 && done == 1'b0, "R1 reset busy/done", 32'({busy, done}), 32'h0);
      rst_n = 1'b1;

      // byte loads
      run_cmd(3'd4, 4'd5, 8'h34, 0, n);
      chk(mem_addr == 16'h0034, "R7 load low", 32'(mem_addr), 32'h0034);
      run_cmd(3'd5, 4'd5, 8'h12, 0, n);
      chk(mem_addr == 16'h1234, "R7 load high keeps low", 32'(mem_addr), 32'h1234);
      run_cmd(3'd4, 4'd5, 8'h35, 0, n);
      chk(mem_addr == 16'h1235, "R7 load low keeps high", 32'(mem_addr), 32'h1235);

      // increment / decrement and wrap
      run_cmd(3'd1, 4'd5, 8'h00, 0, n);
      chk(mem_addr == 16'h1236, "R6 increment", 32'(mem_addr), 32'h1236);
      run_cmd(3'd2, 4'd5, 8'h00, 0, n);
      chk(mem_addr == 16'h1235, "R6 decrement", 32'(mem_addr), 32'h1235);
      run_cmd(3'd4, 4'd2, 8'hFF, 0, n);
      run_cmd(3'd5, 4'd2, 8'hFF, 0, n);
      run_cmd(3'd1, 4'd2, 8'h00, 0, n);
      chk(mem_addr == 16'h0000, "R6 increment wraps to zero", 32'(mem_addr), 32'h0);
      run_cmd(3'd2, 4'd2, 8'h00, 0, n);
      chk(mem_addr == 16'hFFFF, "R6 decrement wraps to all ones", 32'(mem_addr), 32'hFFFF);
      run_cmd(3'd2, 4'd7, 8'h00, 0, n);
      chk(mem_addr == 16'hFFFF, "R1 register cleared by reset then R6 decrement", 32'(mem_addr), 32'hFFFF);

      // fetch with post-increment, with a competing command held during busy
      acc_before = acc;
      run_cmd(3'd3, 4'd5, 8'h00, 1, n);
      chk(addr_tr[0] == 16'h1235, "R8 address at fetch start", 32'(addr_tr[0]), 32'h1235);
      chk(addr_tr[15] == 16'h1235, "R8 pre-increment address through read phase", 32'(addr_tr[15]), 32'h1235);
      chk(addr_tr[16] == 16'h1236, "R8 incremented address in third phase", 32'(addr_tr[16]), 32'h1236);
      chk(acc_tr[15] == acc_before, "R8 acc unchanged before capture", 32'(acc_tr[15]), 32'(acc_before));
      chk(acc_tr[16] == mem_byte(16'h1235), "R8 acc captured at end of read phase",
          32'(acc_tr[16]), 32'(mem_byte(16'h1235)));
      chk(acc == mem_byte(16'h1235), "R8 acc after fetch", 32'(acc), 32'(mem_byte(16'h1235)));
      repeat (10) @(negedge clk);
      chk(busy == 1'b0, "R10 held command not queued", 32'(busy), 32'h0);
      run_cmd(3'd1, 4'd6, 8'h00, 0, n);
      chk(mem_addr == 16'h0001, "R10 command during busy left register 6 alone", 32'(mem_addr), 32'h0001);

      // unused codes
      cmd_valid = 1'b1; cmd_sel = 4'd5; load_data = 8'hEE;
      foreach (acc_tr[i]) if (i < 3) begin
         cmd_op = (i == 0) ? 3'd0 : ((i == 1) ? 3'd6 : 3'd7);
         repeat (20) @(negedge clk);
         chk(busy == 1'b0, "R2 unused code not accepted", 32'(busy), 32'h0);
         chk(mem_addr == 16'h0001, "R2 unused code leaves select and registers", 32'(mem_addr), 32'h0001);
      end
      cmd_valid = 1'b0;

      // sweep: load every register, then fetch each
      for (int i = 0; i < 16; i++) begin
         run_cmd(3'd4, 4'(i), 8'(8'h11 * i) ^ 8'h0F, 0, n);
         run_cmd(3'd5, 4'(i), 8'hC0 | 8'(i), 0, n);
      end
      for (int i = 0; i < 16; i++) begin
         logic [15:0] p;
         p = {8'hC0 | 8'(i), 8'(8'h11 * i) ^ 8'h0F};
         run_cmd(3'd3, 4'(i), 8'h00, 0, n);
         chk(acc == mem_byte(p), "R8 sweep fetch data", 32'(acc), 32'(mem_byte(p)));
         chk(mem_addr == p + 16'd1, "R9 sweep pointer kept and advanced", 32'(mem_addr), 32'(p + 16'd1));
      end

      repeat (4) @(negedge clk);
      finish_up();
   end

endmodule